// File: doc/BRIEF.md
# Periodic Display Snapshot Timer

This block refreshes a two-value numeric display without any store from software. A free-running period counter marks a copy point once per refresh period. At that point the current top-of-stack and next-on-stack register values of the processor are captured into two display latches in one clock cycle, and a one-cycle copy strobe tells the display driver that fresh values are present.

A fixed number of cycles before each copy point the block raises an interrupt request. A handler that wants to show something other than the live stack contents can load its own values into the two stack registers during that window. The copy then picks them up. The request stays high until the processor acknowledges it. A request that is still pending at the copy point does not hold back the copy.

The refresh period and the warning lead are parameters counted in clock cycles. By default they are derived from a clock frequency parameter: 16 ms and 50 µs.

Top module: `disp_snap_timer`

## Requirements
- R1: While reset is asserted, both display latches read zero and irq_o and copy_stb_o are low. After reset is released, counting restarts from zero, so the first copy strobe appears after the PERIOD_CYC-th rising edge.
- R2: copy_stb_o is high for exactly one cycle in every PERIOD_CYC cycles. It is high after rising edge number e (counted from reset release, first edge = 1) exactly when e mod PERIOD_CYC = 0.
- R3: On the edge that raises copy_stb_o, disp_tos_o and disp_nos_o both take the tos_i and nos_i values present at that edge, in the same cycle.
- R4: Between copy edges, disp_tos_o and disp_nos_o hold their values whatever tos_i and nos_i do.
- R5: irq_o is set on edge e when e mod PERIOD_CYC = PERIOD_CYC − LEAD_CYC, which is LEAD_CYC cycles before copy_stb_o rises. It is never raised at any other edge.
- R6: When irq_o is high and irq_ack_i is high at an edge that is not a set edge, irq_o is low after that edge.
- R7: An unacknowledged request stays high through the copy edge, and that copy still takes place.
- R8: When irq_ack_i is high on a set edge, the set wins and irq_o is high after the edge.
- R9: irq_ack_i while irq_o is low has no effect: irq_o stays low and the strobe and latches are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tos_i | input | DATA_W (24) | Processor top-of-stack register value |
| nos_i | input | DATA_W (24) | Processor next-on-stack register value |
| irq_ack_i | input | 1 | Interrupt acknowledge, one or more cycles |
| disp_tos_o | output | DATA_W (24) | Display latch for top-of-stack |
| disp_nos_o | output | DATA_W (24) | Display latch for next-on-stack |
| irq_o | output | 1 | Pre-copy warning interrupt request |
| copy_stb_o | output | 1 | One-cycle pulse after each latch update |

## Verification
The interrupt set at the lead point and the clear by acknowledge can land on the same edge. The bench provokes this in a run that asserts acknowledge exactly at the lead phase, and judges it by requiring irq_o to be high afterwards. The request from that run then stays pending into the copy edge, which shows that the copy and the pending request coexist. Other runs acknowledge a few cycles after the rise, and at a fixed rate that often hits idle cycles. The scoreboard model works out the expected request level edge by edge from the acknowledge it drove.

// File: rtl/snap_pkg.sv
package snap_pkg;

  // Decoded timing events of one refresh period.
  typedef struct packed {
    logic lead;   // warning point: raise the request
    logic copy;   // copy point: capture the registers
  } snap_evt_t;

  // Wrapping increment of the period counter.
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic [31:0] last);
    return (cur == last) ? 32'd0 : cur + 32'd1;
  endfunction

  // Next request level: a set wins over a clear.
  function automatic logic irq_next(input logic cur, input logic set,
                                    input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/snap_period_ctr.sv
module snap_period_ctr
  import snap_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 800000,
  parameter int unsigned LEAD_CYC   = 2500,
  parameter int unsigned CNT_W      = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output snap_evt_t        evt_o
);
  localparam int unsigned COPY_AT = PERIOD_CYC - 1;
  localparam int unsigned LEAD_AT = PERIOD_CYC - 1 - LEAD_CYC;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(step_count(32'(cnt_q), 32'(COPY_AT)));
  end

  assign evt_o.copy = (cnt_q == CNT_W'(COPY_AT));
  assign evt_o.lead = (cnt_q == CNT_W'(LEAD_AT));
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/snap_irq_ctl.sv
module snap_irq_ctl
  import snap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next(irq_q, set_i, ack_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/snap_latch.sv
module snap_latch #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned NUM_REG = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_i,
  input  logic [NUM_REG-1:0][DATA_W-1:0] data_i,
  output logic [NUM_REG-1:0][DATA_W-1:0] data_o,
  output logic                           stb_o
);
  logic stb_q;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic [DATA_W-1:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (load_i) hold_q <= data_i[g];
    end
    assign data_o[g] = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= load_i;
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/disp_snap_timer.sv
module disp_snap_timer
  import snap_pkg::*;
#(
  parameter int unsigned DATA_W     = 24,
  parameter int unsigned CLK_MHZ    = 50,
  parameter int unsigned PERIOD_CYC = CLK_MHZ * 16000,
  parameter int unsigned LEAD_CYC   = CLK_MHZ * 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tos_i,
  input  logic [DATA_W-1:0] nos_i,
  input  logic              irq_ack_i,
  output logic [DATA_W-1:0] disp_tos_o,
  output logic [DATA_W-1:0] disp_nos_o,
  output logic              irq_o,
  output logic              copy_stb_o
);
  localparam int unsigned CNT_W   = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int unsigned NUM_REG = 2;

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] cnt_w;
  snap_evt_t        evt_w;
  logic             lead_evt_w;
  logic             copy_evt_w;

  logic [NUM_REG-1:0][DATA_W-1:0] src_w;
  logic [NUM_REG-1:0][DATA_W-1:0] shown_w;

  snap_period_ctr #(
    .PERIOD_CYC(PERIOD_CYC),
    .LEAD_CYC  (LEAD_CYC),
    .CNT_W     (CNT_W)
  ) ctr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt_o(cnt_w),
    .evt_o(evt_w)
  );

  assign lead_evt_w = evt_w.lead;
  assign copy_evt_w = evt_w.copy;

  snap_irq_ctl irq_i (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(lead_evt_w),
    .ack_i(irq_ack_i),
    .irq_o(irq_o)
  );

  assign src_w[0] = tos_i;
  assign src_w[1] = nos_i;

  snap_latch #(
    .DATA_W (DATA_W),
    .NUM_REG(NUM_REG)
  ) latch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(copy_evt_w),
    .data_i(src_w),
    .data_o(shown_w),
    .stb_o (copy_stb_o)
  );

  assign disp_tos_o = shown_w[0];
  assign disp_nos_o = shown_w[1];
endmodule

// File: rtl/disp_snap_chk.sv
module disp_snap_chk #(
  parameter int unsigned DATA_W     = 24,
  parameter int unsigned PERIOD_CYC = 800000,
  parameter int unsigned CNT_W      = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] tos_i,
  input logic [DATA_W-1:0] nos_i,
  input logic              irq_ack_i,
  input logic [DATA_W-1:0] disp_tos_o,
  input logic [DATA_W-1:0] disp_nos_o,
  input logic              irq_o,
  input logic              copy_stb_o,
  input logic [CNT_W-1:0]  cnt_w,
  input logic              lead_evt_w,
  input logic              copy_evt_w
);
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt_w |=> (cnt_w == '0)); // R1

  AST_STROBE_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt_w |=> copy_stb_o); // R2

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copy_stb_o) |-> $past(copy_evt_w)); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    copy_stb_o |=> !copy_stb_o); // R2

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt_w |=> (disp_tos_o == $past(tos_i)) && (disp_nos_o == $past(nos_i))); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_evt_w |=> $stable(disp_tos_o) && $stable(disp_nos_o)); // R4

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lead_evt_w |=> irq_o); // R5

  AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(lead_evt_w)); // R9

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && irq_ack_i && !lead_evt_w |=> !irq_o); // R6

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_ack_i |=> irq_o); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lead_evt_w && irq_ack_i |=> irq_o); // R8
endmodule

bind disp_snap_timer disp_snap_chk #(
  .DATA_W    (DATA_W),
  .PERIOD_CYC(PERIOD_CYC),
  .CNT_W     (CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tos_i     (tos_i),
  .nos_i     (nos_i),
  .irq_ack_i (irq_ack_i),
  .disp_tos_o(disp_tos_o),
  .disp_nos_o(disp_nos_o),
  .irq_o     (irq_o),
  .copy_stb_o(copy_stb_o),
  .cnt_w     (cnt_w),
  .lead_evt_w(lead_evt_w),
  .copy_evt_w(copy_evt_w)
);

// File: tb/disp_snap_timer_tb_top.sv
module disp_snap_timer_tb_top;
  localparam int P  = 40;
  localparam int L  = 8;
  localparam int DW = 24;

  typedef struct {
    int          edge_no;
    logic [DW-1:0] tos;
    logic [DW-1:0] nos;
    logic        ack;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] tos_i = '0;
  logic [DW-1:0] nos_i = '0;
  logic          irq_ack_i = 1'b0;
  logic [DW-1:0] disp_tos_o, disp_nos_o;
  logic          irq_o, copy_stb_o;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int next_edge = 1;
  bit done = 0;
  item_t q[$];

  logic          exp_irq = 1'b0;
  logic [DW-1:0] exp_tos = '0;
  logic [DW-1:0] exp_nos = '0;

  always #10 clk = ~clk;  // 50 MHz

  disp_snap_timer #(.DATA_W(DW), .PERIOD_CYC(P), .LEAD_CYC(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .tos_i(tos_i), .nos_i(nos_i),
    .irq_ack_i(irq_ack_i), .disp_tos_o(disp_tos_o), .disp_nos_o(disp_nos_o),
    .irq_o(irq_o), .copy_stb_o(copy_stb_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (edge %0d)", tag, what, act, exp, edges);
    end
  endtask

  // Monitor: pops the item driven for the edge just taken and compares.
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      exp_irq = 1'b0; exp_tos = '0; exp_nos = '0;
      check("R1", "reset tos", 32'(disp_tos_o), 32'(0));
      check("R1", "reset nos", 32'(disp_nos_o), 32'(0));
      check("R1", "reset irq", 32'(irq_o), 32'(0));
      check("R1", "reset stb", 32'(copy_stb_o), 32'(0));
    end else if (q.size() > 0 && q[0].edge_no == edges) begin
      item_t it;
      int ph;
      string itag;
      string dtag;
      it = q.pop_front();
      ph = it.edge_no % P;
      if (ph == P - L)           itag = it.ack ? "R8" : "R5";
      else if (it.ack && exp_irq) itag = "R6";
      else if (it.ack)            itag = "R9";
      else if (ph == 0)           itag = "R7";
      else                        itag = "R5";
      if (ph == P - L)  exp_irq = 1'b1;
      else if (it.ack)  exp_irq = 1'b0;
      dtag = "R4";
      if (ph == 0) begin
        exp_tos = it.tos; exp_nos = it.nos; dtag = "R3";
      end
      check(it.edge_no == P ? "R1" : "R2", "copy strobe",
            32'(copy_stb_o), 32'(ph == 0));
      check(itag, "irq", 32'(irq_o), 32'(exp_irq));
      check(dtag, "disp tos", 32'(disp_tos_o), 32'(exp_tos));
      check(dtag, "disp nos", 32'(disp_nos_o), 32'(exp_nos));
    end
  end

  function automatic logic [DW-1:0] mix(input int e, input int salt);
    return DW'(32'(e) * 32'h009E3779 ^ 32'(salt));
  endfunction

  // Driver: sets inputs for the next edge and pushes the expected item.
  // mode 0: no ack; 1: ack 3 cycles after rise; 2: ack on the set edge;
  // 3: ack every 5th cycle. pat 1 uses all-ones / all-zeros data.
  task automatic drive_run(input int n, input int mode, input int pat);
    for (int k = 0; k < n; k++) begin
      item_t it;
      int ph;
      ph = next_edge % P;
      it.edge_no = next_edge;
      case (mode)
        1:       it.ack = (ph == (P - L + 3) % P);
        2:       it.ack = (ph == P - L);
        3:       it.ack = (ph % 5 == 1);
        default: it.ack = 1'b0;
      endcase
      if (pat == 1) begin
        it.tos = (next_edge % 2 == 0) ? '1 : '0;
        it.nos = ~it.tos;
      end else begin
        it.tos = mix(next_edge, 32'h5a5a5a + mode);
        it.nos = mix(next_edge + 7, 32'h0c3c3c ^ mode);
      end
      tos_i = it.tos; nos_i = it.nos; irq_ack_i = it.ack;
      q.push_back(it);
      next_edge++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_ack_i = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    next_edge = 1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();                 // R1 reset values, first strobe at edge P
    drive_run(3 * P, 0, 0);     // R2 R3 R4 R5 R7 no acknowledge
    drive_run(3 * P, 1, 0);     // R6 acknowledge after rise
    drive_run(2 * P, 2, 1);     // R8 set/ack collision, R7 pending copy, boundary data
    drive_run(3 * P, 3, 0);     // R9 idle acknowledges
    drive_run(P - L + 2, 0, 0); // leave a request pending
    do_reset();                 // R1 reset mid-period with irq pending
    drive_run(2 * P + 3, 1, 1);
    @(negedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule